// File: doc/BRIEF.md
# Recursive Moving-Average Audio Filter

This block smooths one channel of signed audio by averaging the most recent N samples. It does not keep a delay line with an adder tree. Each arriving sample is first divided by N with a sign-preserving right shift. The scaled value goes into an N-deep circular queue and into a single running sum. The sum also takes back the scaled value that drops out of the queue. Every new sample therefore costs one addition path and one memory write.

The filter state moves only when the sample strobe is high. The queue and the running sum always advance on the same clock edge. After reset the queue counts as N zeros, so the output ramps up from zero over the first N samples. A bypass select routes the raw input to the registered output in place of the average. The filter keeps absorbing strobed samples while bypass is set. One instance serves one channel. N is a compile-time power of two, and the shift amount is derived from it.

Top module: `mavg_filter`

## Requirements
- R1: While reset is high, the output register and the running sum clear to zero; the first cycle after reset shows an output of 0.
- R2: Each sample is treated as a signed two's-complement value and scaled by an arithmetic right shift of log2(N) bits, so the result rounds toward minus infinity (an input of -1 contributes -1, an input of 7 contributes 0 when N is 8).
- R3: Once at least N samples have been strobed in, the filtered output equals the sum of the scaled versions of the last N strobed samples, across any number of queue wrap-arounds.
- R4: Before N samples have arrived, the filtered output equals the sum of the scaled samples received so far, with the empty slots counting as zero.
- R5: The queue and the running sum change only on a clock edge where the strobe is high; with the strobe low, the filtered output holds its value whatever the sample input does.
- R6: With bypass high, the output is the sample input registered by one clock. The filter state still advances on strobes, and after bypass is cleared the output is the correct average of all samples strobed so far.
- R7: A sample strobed at clock edge k appears in the filtered output after clock edge k+1, one register after the running sum.
- R8: The running sum stays within the sample width with no wrap for any input, including N full-scale negative (-2^23) or full-scale positive (2^23-1) samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe; high for one clock per new sample |
| smp_in | input | 24 | Signed input sample |
| bypass | input | 1 | 1 routes the raw input to the output, 0 the average |
| smp_out | output | 24 | Registered output sample |

## Verification
A corrupted queue slot or a missed removal leaves the running sum with an offset. The bench catches that offset in the output two edges after the strobe that caused it. The offset then persists, because the sum is recursive and never resynchronises. A write pointer that steps wrongly, or that steps without a strobe, shows up N samples later, when the wrong slot is taken back out. For that reason the bench compares every output over several hundred strobes, well past many wraps. A start-up fault shows within the first N samples as a ramp that does not match the partial sums.

// File: rtl/mavg_pkg.sv
package mavg_pkg;
  localparam int unsigned SAMPLE_W = 24;
  localparam int unsigned TAPS_DEF = 8;

  function automatic bit is_pow2(input int unsigned v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/mavg_prescale.sv
module mavg_prescale #(
  parameter int unsigned W     = 24,
  parameter int unsigned SHIFT = 3
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (SHIFT == 0) begin : g_pass
      assign dout = din;
    end else begin : g_shift
      // sign bit replicated into the vacated high positions
      assign dout = {{SHIFT{din[W-1]}}, din[W-1:SHIFT]};
    end
  endgenerate
endmodule

// File: rtl/mavg_ring.sv
module mavg_ring #(
  parameter int unsigned W     = 24,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] oldest
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr;
  logic          full;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      full <= 1'b0;
    end else if (push) begin
      wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (wptr == LAST) full <= 1'b1;
    end
  end

  // slots not yet written count as zero
  assign oldest = full ? mem[wptr] : '0;

  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (push && wptr == LAST) |=> (wptr == '0 && full));

  p_ptr_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !push |=> $stable(wptr));
endmodule

// File: rtl/mavg_accum.sv
module mavg_accum #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] add_in,
  input  logic [W-1:0] sub_in,
  output logic [W-1:0] acc
);
  logic [W-1:0] neg_sub;
  assign neg_sub = ~sub_in + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= acc + add_in + neg_sub;
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc));

  // a non-negative sum growing by non-negative steps must not wrap negative
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (en && !acc[W-1] && !add_in[W-1] && (sub_in[W-1] || sub_in == '0))
      |=> !acc[W-1]);
endmodule

// File: rtl/mavg_filter.sv
module mavg_filter #(
  parameter int unsigned W    = mavg_pkg::SAMPLE_W,
  parameter int unsigned TAPS = mavg_pkg::TAPS_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_in,
  input  logic         bypass,
  output logic [W-1:0] smp_out
);
  localparam int unsigned SHIFT = $clog2(TAPS);

  initial begin
    if (!mavg_pkg::is_pow2(TAPS))
      $error("TAPS must be a power of two of at least 2");
  end

  logic [W-1:0] scaled;
  logic [W-1:0] leaving;
  logic [W-1:0] run_sum;

  mavg_prescale #(.W(W), .SHIFT(SHIFT)) u_scale (
    .din  (smp_in),
    .dout (scaled)
  );

  mavg_ring #(.W(W), .DEPTH(TAPS)) u_ring (
    .clk    (clk),
    .rst    (rst),
    .push   (smp_valid),
    .din    (scaled),
    .oldest (leaving)
  );

  mavg_accum #(.W(W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .en     (smp_valid),
    .add_in (scaled),
    .sub_in (leaving),
    .acc    (run_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) smp_out <= '0;
    else     smp_out <= bypass ? smp_in : run_sum;
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (smp_out == '0 && run_sum == '0));
endmodule

// File: tb/tb_mavg_filter.sv
module tb_mavg_filter;
  localparam int W = 24;
  localparam int N = 8;
  localparam int SH = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [W-1:0] smp_in = '0;
  logic bypass = 1'b0;
  logic [W-1:0] smp_out;

  int n_cmp = 0;
  int n_bad = 0;
  int hist [N];
  int hptr = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  mavg_filter #(.W(W), .TAPS(N)) dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid),
    .smp_in(smp_in), .bypass(bypass), .smp_out(smp_out)
  );

  function automatic int scale(input logic [W-1:0] x);
    int v;
    v = $signed(x);
    return v >>> SH;
  endfunction

  function automatic int model_sum();
    int s = 0;
    for (int i = 0; i < N; i++) s += hist[i];
    return s;
  endfunction

  function automatic int unsigned rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outv();
    int v;
    v = $signed(smp_out);
    return v;
  endfunction

  // strobe one sample, update the model, return once the output is visible
  task automatic push(input logic [W-1:0] x);
    @(negedge clk);
    smp_in = x; smp_valid = 1'b1;
    hist[hptr] = scale(x);
    hptr = (hptr + 1) % N;
    @(negedge clk);
    smp_valid = 1'b0;
    smp_in = W'(rnd());
    @(negedge clk);
  endtask

  task automatic clear_model();
    for (int i = 0; i < N; i++) hist[i] = 0;
    hptr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; smp_valid = 1'b0; bypass = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    clear_model();
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    clear_model();
    do_reset();
    check("R1 output after reset", outv(), 0);

    // R4 start-up ramp, R7 latency
    for (int k = 1; k < N; k++) begin
      push(W'(k * 800));
      check("R4 partial sum", outv(), model_sum());
    end
    // R7: one cycle after the strobe edge the new sample is not yet visible
    @(negedge clk);
    smp_in = W'(16000); smp_valid = 1'b1;
    hist[hptr] = scale(W'(16000)); hptr = (hptr + 1) % N;
    @(negedge clk);
    smp_valid = 1'b0;
    check("R7 not visible yet", outv(), model_sum() - scale(W'(16000)));
    @(negedge clk);
    check("R7 visible after next edge", outv(), model_sum());

    // R2 rounding of small and negative values
    do_reset();
    push(W'(-1));
    check("R2 minus one scales to -1", outv(), -1);
    push(W'(7));
    check("R2 seven scales to 0", outv(), -1);
    push(W'(-9));
    check("R2 minus nine scales to -2", outv(), -3);

    // R3 long sweep with many wraps
    for (int k = 0; k < 400; k++) begin
      push(W'(rnd()));
      check("R3 steady-state sum", outv(), model_sum());
    end

    // R5 hold with strobe low while input wanders
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      smp_in = W'(rnd());
      check("R5 hold without strobe", outv(), model_sum());
    end

    // R6 bypass, filter keeps running underneath
    @(negedge clk);
    bypass = 1'b1; smp_in = W'(24'h5A5A5A);
    @(negedge clk);
    check("R6 bypass passes input", outv(), $signed(24'h5A5A5A));
    smp_in = W'(24'h812345);
    @(negedge clk);
    check("R6 bypass negative input", outv(), $signed(24'h812345));
    push(W'(300000));
    push(W'(-500000));
    @(negedge clk);
    bypass = 1'b0;
    @(negedge clk);
    check("R6 average after bypass", outv(), model_sum());

    // R8 full-scale extremes
    do_reset();
    for (int k = 0; k < N; k++) push(24'h800000);
    check("R8 full negative", outv(), -(1 << 23));
    for (int k = 0; k < N; k++) push(24'h7FFFFF);
    check("R8 full positive", outv(), ((1 << 20) - 1) * N);
    for (int k = 0; k < N + 3; k++) begin
      push((k % 2) ? 24'h800000 : 24'h7FFFFF);
      check("R8 alternating extremes", outv(), model_sum());
    end

    // R1 reset mid-stream
    do_reset();
    check("R1 output after second reset", outv(), 0);
    push(W'(8000));
    check("R4 first sample after reset", outv(), 1000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule